// File: doc/BRIEF.md
# Adaptive Write-and-Verify Programming Sequencer

This block is the host-side controller for one-time-programmable memory. It drives a serial command engine that sits next to it. That engine does the bit-level shifting; this block decides which command comes next. The controller writes every user word with a pulse-count that adapts to the word. It then re-reads the whole user array at the low supply corner and again at the high supply corner. After that it writes the four identification words and the configuration word. It finishes with one status code.

Commands leave the block over a request/acknowledge pair. Each request is held until the engine acknowledges it. The block then waits at least one microsecond before it raises the next request. The block times each programming pulse itself, between its start-pulse command and its stop-pulse command. Every interval is a count of system clocks, derived from a clocks-per-microsecond parameter. Expected words come from a small image port that reads combinationally. Image indices are laid out as follows:

- user words occupy `0..USER_WORDS-1`;
- the identification words follow;
- the configuration word takes the last index.

Three outputs select the supply level that external circuitry must apply: programming, minimum or maximum.

Top module: `prog_algo_seq`

## Requirements
- R1: `cmd_req` stays high with `cmd_code` and `cmd_wdata` unchanged until the cycle in which `cmd_ack` is high, and it is low in the following cycle. Command codes are: 0 load-config (target address moves to the first identification word), 1 load-word, 2 read-word, 3 step-address, 4 start-pulse, 5 stop-pulse, 6 re-enter (target address back to user word 0).
- R2: After an acknowledge, `cmd_req` stays low for at least `CLK_PER_US*GAP_US` clocks before it rises again.
- R3: A load (code 0 or 1) is acknowledged between any two start-pulse commands and before the first one. From the acknowledge of a start-pulse to the rise of the request for the following stop-pulse, at least `CLK_PER_US*PULSE_US` clocks pass.
- R4: For each user word, attempt N is this sequence: load, one pulse, read, compare. Attempts repeat until the read-back matches the image word. The word then gets 3N further load-and-pulse cycles, then a step-address. A word that matches on attempt N therefore receives exactly 4N pulses.
- R5: If attempt `MAX_TRIES` (25) still reads back wrong for a user word, the run ends with status 1. That word has received exactly 25 pulses, and no later word is touched.
- R6: After all user words are written, the block re-enters and reads every user word while `sup_min` is high. The first mismatch ends the run with status 2, and `sup_max` is never raised in that run.
- R7: After the minimum-supply verify passes, the same read-back runs with `sup_max` high. A mismatch ends the run with status 3, and no identification word is programmed.
- R8: The identification phase opens with load-config carrying the first identification word. All four identification words then use the algorithm of R4. Exhausting the attempts on one of them ends the run with status 4.
- R9: After the last identification word, three more step-address commands reach the configuration word. It then receives exactly `CFG_CYCLES` (100) load-and-pulse cycles, then one read at minimum supply and one at maximum supply. A mismatch at either corner gives status 4.
- R10: At most one of `sup_prog`, `sup_min`, `sup_max` is high at any time. `sup_prog` is high at every start-pulse, and exactly one supply line is high at every read.
- R11: After reset, `done`, `cmd_req` and all supply lines are low. A fully passing run ends with status 0. `done` and `status` then hold, with no requests, until the next `start`.
- R12: The data of every load command equals the image word for the location that the target address currently points to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a full run when idle or done |
| done | output | 1 | Run finished; status valid |
| status | output | 3 | 0 pass, 1 program failure, 2 low-supply verify, 3 high-supply verify, 4 identification/configuration |
| cmd_req | output | 1 | Command request to the serial engine |
| cmd_code | output | 3 | Command code (see R1) |
| cmd_wdata | output | 14 | Data word sent with load commands |
| cmd_ack | input | 1 | One-cycle acknowledge; read data valid with it |
| cmd_rdata | input | 14 | Word read back by a read-word command |
| img_addr | output | $clog2(USER_WORDS+5) | Image index of the current location |
| img_data | input | 14 | Expected word at `img_addr`, combinational |
| sup_prog | output | 1 | Select programming supply |
| sup_min | output | 1 | Select minimum supply |
| sup_max | output | 1 | Select maximum supply |

## Verification
A wrong attempt counter or extra-cycle count shows up at the engine as a pulse total per location that differs from 4N. The bench's engine model counts start-pulses per address, so the error is visible as soon as that location's step-address is acknowledged. A wrong phase register shows immediately on the supply lines during the next read, or as a wrong status once `done` rises. Timing faults in the command port or pulse timer show at the next request edge as a gap or pulse shorter than its clock budget.

// File: rtl/psq_pkg.sv
package psq_pkg;

    localparam int WORD_W   = 14;
    localparam int ID_WORDS = 4;
    localparam int CFG_SKIP = 3;

    typedef enum logic [2:0] {
        CMD_LDCFG = 3'd0,
        CMD_LDDAT = 3'd1,
        CMD_READ  = 3'd2,
        CMD_INC   = 3'd3,
        CMD_BEGIN = 3'd4,
        CMD_END   = 3'd5,
        CMD_ENTER = 3'd6,
        CMD_NONE  = 3'd7
    } cmd_e;

    typedef enum logic [2:0] {
        PH_IDLE, PH_USER, PH_VMIN, PH_VMAX, PH_ID, PH_CFG, PH_CMIN, PH_CMAX
    } phase_e;

    typedef enum logic [1:0] {
        PM_TRY, PM_EXTRA, PM_CFG
    } pmode_e;

    typedef struct packed {
        logic prog;
        logic vmin;
        logic vmax;
    } supply_t;

    localparam logic [2:0] ST_PASS  = 3'd0;
    localparam logic [2:0] ST_PROG  = 3'd1;
    localparam logic [2:0] ST_VMIN  = 3'd2;
    localparam logic [2:0] ST_VMAX  = 3'd3;
    localparam logic [2:0] ST_IDCFG = 3'd4;

    function automatic supply_t supply_of(phase_e p);
        supply_t s;
        s.prog = (p == PH_USER) || (p == PH_ID) || (p == PH_CFG);
        s.vmin = (p == PH_VMIN) || (p == PH_CMIN);
        s.vmax = (p == PH_VMAX) || (p == PH_CMAX);
        return s;
    endfunction

endpackage

// File: rtl/psq_cmd_port.sv
module psq_cmd_port
    import psq_pkg::*;
#(
    parameter int GAP_CYC = 50
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  cmd_e              code_in,
    input  logic [WORD_W-1:0] data_in,
    input  logic              ack,
    input  logic [WORD_W-1:0] rdata_in,
    output logic              req,
    output cmd_e              code_q,
    output logic [WORD_W-1:0] wdata_q,
    output logic [WORD_W-1:0] rdata_q,
    output logic              fin
);
    localparam int GC = (GAP_CYC < 1) ? 1 : GAP_CYC;
    localparam int GW = $clog2(GC + 1);

    typedef enum logic [1:0] {P_IDLE, P_REQ, P_GAP} pstate_e;

    pstate_e         st_q;
    logic [GW-1:0]   gap_q;

    assign req = (st_q == P_REQ);
    assign fin = (st_q == P_GAP) && (gap_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= P_IDLE;
            gap_q   <= '0;
            code_q  <= CMD_NONE;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            case (st_q)
                P_IDLE: if (go) begin
                    code_q  <= code_in;
                    wdata_q <= data_in;
                    st_q    <= P_REQ;
                end
                P_REQ: if (ack) begin
                    rdata_q <= rdata_in;
                    gap_q   <= GW'(GC - 1);
                    st_q    <= P_GAP;
                end
                P_GAP: begin
                    if (gap_q == '0) st_q <= P_IDLE;
                    else             gap_q <= gap_q - 1'b1;
                end
                default: st_q <= P_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/psq_pulse_timer.sv
module psq_pulse_timer #(
    parameter int CYC = 5000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic expired
);
    localparam int CC = (CYC < 1) ? 1 : CYC;
    localparam int TW = $clog2(CC + 1);

    logic [TW-1:0] cnt_q;
    logic          run_q;

    assign expired = run_q && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (start) begin
            cnt_q <= TW'(CC - 1);
            run_q <= 1'b1;
        end else if (run_q) begin
            if (cnt_q == '0) run_q <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/psq_tries.sv
module psq_tries #(
    parameter int MAX_TRIES = 25
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic bump,
    input  logic load_extra,
    input  logic dec_extra,
    output logic at_max,
    output logic extra_zero
);
    localparam int NW = $clog2(MAX_TRIES + 1);
    localparam int EW = NW + 2;

    logic [NW-1:0] n_q;
    logic [EW-1:0] extra_q;

    assign at_max     = (n_q >= NW'(MAX_TRIES));
    assign extra_zero = (extra_q == '0);

    always_ff @(posedge clk) begin
        if (rst || clr) n_q <= '0;
        else if (bump)  n_q <= n_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            extra_q <= '0;
        else if (load_extra)
            extra_q <= {1'b0, n_q, 1'b0} + {2'b00, n_q};
        else if (dec_extra && !extra_zero)
            extra_q <= extra_q - 1'b1;
    end
endmodule

// File: rtl/prog_algo_seq.sv
module prog_algo_seq
    import psq_pkg::*;
#(
    parameter int CLK_PER_US = 50,
    parameter int PULSE_US   = 100,
    parameter int GAP_US     = 1,
    parameter int USER_WORDS = 16,
    parameter int MAX_TRIES  = 25,
    parameter int CFG_CYCLES = 100
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 start,
    output logic                                 done,
    output logic [2:0]                           status,
    output logic                                 cmd_req,
    output logic [2:0]                           cmd_code,
    output logic [13:0]                          cmd_wdata,
    input  logic                                 cmd_ack,
    input  logic [13:0]                          cmd_rdata,
    output logic [$clog2(USER_WORDS+5)-1:0]      img_addr,
    input  logic [13:0]                          img_data,
    output logic                                 sup_prog,
    output logic                                 sup_min,
    output logic                                 sup_max
);
    localparam int IMG_WORDS = USER_WORDS + ID_WORDS + 1;
    localparam int IAW       = $clog2(IMG_WORDS);
    localparam int PULSE_CYC = CLK_PER_US * PULSE_US;
    localparam int GAP_CYC   = CLK_PER_US * GAP_US;
    localparam int CW        = $clog2(CFG_CYCLES + 1);
    localparam logic [IAW-1:0] LAST_USER = IAW'(USER_WORDS - 1);
    localparam logic [IAW-1:0] ID_BASE   = IAW'(USER_WORDS);
    localparam logic [IAW-1:0] LAST_ID   = IAW'(USER_WORDS + ID_WORDS - 1);
    localparam logic [IAW-1:0] CFG_IDX   = IAW'(USER_WORDS + ID_WORDS);

    typedef enum logic [4:0] {
        S_IDLE, S_ENTER, S_LDCFG, S_LOAD, S_BEGIN, S_PULSE, S_ENDP, S_READ,
        S_CHECK, S_XNEXT, S_INC, S_SKIP, S_VREAD, S_VCHK, S_VINC, S_CREAD,
        S_CCHK, S_DONE
    } state_e;

    state_e            state_q;
    phase_e            phase_q;
    pmode_e            pmode_q;
    logic [IAW-1:0]    idx_q;
    logic              issued_q;
    logic [1:0]        skip_q;
    logic [CW-1:0]     cfg_left_q;
    logic              done_q;
    logic [2:0]        status_q;

    cmd_e              cmd_sel;
    logic              is_cmd;
    logic              go, fin, tmr_start, expired;
    cmd_e              port_code;
    logic [WORD_W-1:0] port_rdata;
    logic              match;
    logic              tr_clr, tr_bump, tr_load, tr_dec;
    logic              at_max, extra_zero;
    supply_t           sup;

    // Command selected by the current step
    always_comb begin
        cmd_sel = CMD_NONE;
        case (state_q)
            S_ENTER:                 cmd_sel = CMD_ENTER;
            S_LDCFG:                 cmd_sel = CMD_LDCFG;
            S_LOAD:                  cmd_sel = CMD_LDDAT;
            S_BEGIN:                 cmd_sel = CMD_BEGIN;
            S_ENDP:                  cmd_sel = CMD_END;
            S_READ, S_VREAD, S_CREAD: cmd_sel = CMD_READ;
            S_INC, S_SKIP, S_VINC:   cmd_sel = CMD_INC;
            default:                 cmd_sel = CMD_NONE;
        endcase
    end

    assign is_cmd    = (cmd_sel != CMD_NONE);
    assign go        = is_cmd && !issued_q;
    assign tmr_start = (state_q == S_PULSE) && !issued_q;
    assign match     = (port_rdata == img_data);

    assign tr_clr  = fin && (((state_q == S_ENTER) && (phase_q == PH_USER)) ||
                             (state_q == S_LDCFG) || (state_q == S_INC));
    assign tr_bump = fin && (state_q == S_BEGIN) && (pmode_q == PM_TRY);
    assign tr_load = (state_q == S_CHECK) && match;
    assign tr_dec  = fin && (state_q == S_ENDP) && (pmode_q == PM_EXTRA);

    psq_cmd_port #(.GAP_CYC(GAP_CYC)) u_port (
        .clk      (clk),
        .rst      (rst),
        .go       (go),
        .code_in  (cmd_sel),
        .data_in  (img_data),
        .ack      (cmd_ack),
        .rdata_in (cmd_rdata),
        .req      (cmd_req),
        .code_q   (port_code),
        .wdata_q  (cmd_wdata),
        .rdata_q  (port_rdata),
        .fin      (fin)
    );

    psq_pulse_timer #(.CYC(PULSE_CYC)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .start   (tmr_start),
        .expired (expired)
    );

    psq_tries #(.MAX_TRIES(MAX_TRIES)) u_tries (
        .clk        (clk),
        .rst        (rst),
        .clr        (tr_clr),
        .bump       (tr_bump),
        .load_extra (tr_load),
        .dec_extra  (tr_dec),
        .at_max     (at_max),
        .extra_zero (extra_zero)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= S_IDLE;
            phase_q    <= PH_IDLE;
            pmode_q    <= PM_TRY;
            idx_q      <= '0;
            issued_q   <= 1'b0;
            skip_q     <= '0;
            cfg_left_q <= '0;
            done_q     <= 1'b0;
            status_q   <= ST_PASS;
        end else begin
            if (go || tmr_start)      issued_q <= 1'b1;
            else if (fin || expired)  issued_q <= 1'b0;

            case (state_q)
                S_IDLE, S_DONE: if (start) begin
                    done_q  <= 1'b0;
                    phase_q <= PH_USER;
                    idx_q   <= '0;
                    state_q <= S_ENTER;
                end
                S_ENTER: if (fin) begin
                    case (phase_q)
                        PH_USER: begin pmode_q <= PM_TRY; state_q <= S_LOAD; end
                        PH_ID:   state_q <= S_LDCFG;
                        default: state_q <= S_VREAD;
                    endcase
                end
                S_LDCFG: if (fin) begin
                    pmode_q <= PM_TRY;
                    state_q <= S_BEGIN;
                end
                S_LOAD:  if (fin) state_q <= S_BEGIN;
                S_BEGIN: if (fin) state_q <= S_PULSE;
                S_PULSE: if (expired) state_q <= S_ENDP;
                S_ENDP: if (fin) begin
                    case (pmode_q)
                        PM_TRY:   state_q <= S_READ;
                        PM_EXTRA: state_q <= S_XNEXT;
                        default: begin
                            cfg_left_q <= cfg_left_q - 1'b1;
                            if (cfg_left_q == CW'(1)) begin
                                phase_q <= PH_CMIN;
                                state_q <= S_CREAD;
                            end else begin
                                state_q <= S_LOAD;
                            end
                        end
                    endcase
                end
                S_READ: if (fin) state_q <= S_CHECK;
                S_CHECK: begin
                    if (match) begin
                        state_q <= S_XNEXT;
                    end else if (at_max) begin
                        status_q <= (phase_q == PH_ID) ? ST_IDCFG : ST_PROG;
                        done_q   <= 1'b1;
                        phase_q  <= PH_IDLE;
                        state_q  <= S_DONE;
                    end else begin
                        state_q <= S_LOAD;
                    end
                end
                S_XNEXT: begin
                    if (extra_zero) begin
                        state_q <= S_INC;
                    end else begin
                        pmode_q <= PM_EXTRA;
                        state_q <= S_LOAD;
                    end
                end
                S_INC: if (fin) begin
                    if (phase_q == PH_USER && idx_q == LAST_USER) begin
                        phase_q <= PH_VMIN;
                        idx_q   <= '0;
                        state_q <= S_ENTER;
                    end else if (phase_q == PH_ID && idx_q == LAST_ID) begin
                        skip_q  <= 2'(CFG_SKIP);
                        state_q <= S_SKIP;
                    end else begin
                        idx_q   <= idx_q + 1'b1;
                        pmode_q <= PM_TRY;
                        state_q <= S_LOAD;
                    end
                end
                S_SKIP: if (fin) begin
                    skip_q <= skip_q - 1'b1;
                    if (skip_q == 2'd1) begin
                        idx_q      <= CFG_IDX;
                        phase_q    <= PH_CFG;
                        pmode_q    <= PM_CFG;
                        cfg_left_q <= CW'(CFG_CYCLES);
                        state_q    <= S_LOAD;
                    end
                end
                S_VREAD: if (fin) state_q <= S_VCHK;
                S_VCHK: begin
                    if (!match) begin
                        status_q <= (phase_q == PH_VMIN) ? ST_VMIN : ST_VMAX;
                        done_q   <= 1'b1;
                        phase_q  <= PH_IDLE;
                        state_q  <= S_DONE;
                    end else if (idx_q == LAST_USER) begin
                        if (phase_q == PH_VMIN) begin
                            phase_q <= PH_VMAX;
                            idx_q   <= '0;
                        end else begin
                            phase_q <= PH_ID;
                            idx_q   <= ID_BASE;
                        end
                        state_q <= S_ENTER;
                    end else begin
                        state_q <= S_VINC;
                    end
                end
                S_VINC: if (fin) begin
                    idx_q   <= idx_q + 1'b1;
                    state_q <= S_VREAD;
                end
                S_CREAD: if (fin) state_q <= S_CCHK;
                S_CCHK: begin
                    if (!match) begin
                        status_q <= ST_IDCFG;
                        done_q   <= 1'b1;
                        phase_q  <= PH_IDLE;
                        state_q  <= S_DONE;
                    end else if (phase_q == PH_CMIN) begin
                        phase_q <= PH_CMAX;
                        state_q <= S_CREAD;
                    end else begin
                        status_q <= ST_PASS;
                        done_q   <= 1'b1;
                        phase_q  <= PH_IDLE;
                        state_q  <= S_DONE;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign sup      = supply_of(phase_q);
    assign sup_prog = sup.prog;
    assign sup_min  = sup.vmin;
    assign sup_max  = sup.vmax;
    assign cmd_code = port_code;
    assign img_addr = idx_q;
    assign done     = done_q;
    assign status   = status_q;

endmodule

// File: rtl/psq_seq_chk.sv
module psq_seq_chk #(
    parameter int GAP_CYC   = 50,
    parameter int PULSE_CYC = 5000
) (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        done,
    input logic [2:0]  status,
    input logic        cmd_req,
    input logic [2:0]  cmd_code,
    input logic [13:0] cmd_wdata,
    input logic        cmd_ack,
    input logic        sup_prog,
    input logic        sup_min,
    input logic        sup_max
);
    logic [31:0] gap_cnt, pulse_cnt;
    logic        loaded;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_cnt   <= 32'(GAP_CYC);
            pulse_cnt <= 32'(PULSE_CYC);
            loaded    <= 1'b0;
        end else begin
            if (cmd_ack) gap_cnt <= '0;
            else if (!cmd_req && gap_cnt < 32'(GAP_CYC)) gap_cnt <= gap_cnt + 1;

            if (cmd_ack && cmd_code == 3'd4) pulse_cnt <= '0;
            else if (pulse_cnt < 32'(PULSE_CYC)) pulse_cnt <= pulse_cnt + 1;

            if (cmd_ack && (cmd_code == 3'd0 || cmd_code == 3'd1)) loaded <= 1'b1;
            else if (cmd_ack && cmd_code == 3'd4)                  loaded <= 1'b0;
        end
    end

    // R1
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_req && !cmd_ack |=> cmd_req && $stable(cmd_code) && $stable(cmd_wdata));

    // R1
    req_drop_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_ack |=> !cmd_req);

    // R2
    cmd_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cmd_req) |-> gap_cnt >= 32'(GAP_CYC));

    // R3
    load_first_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_req && cmd_code == 3'd4 |-> loaded);

    // R3
    pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cmd_req) && cmd_code == 3'd5 |-> pulse_cnt >= 32'(PULSE_CYC));

    // R10
    supply_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sup_prog, sup_min, sup_max}));

    // R10
    begin_supply_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_req && cmd_code == 3'd4 |-> sup_prog);

    // R11
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        done && !start |=> done && $stable(status));

    // R11
    done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !cmd_req);

endmodule

bind prog_algo_seq psq_seq_chk #(
    .GAP_CYC   (GAP_CYC),
    .PULSE_CYC (PULSE_CYC)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .done      (done),
    .status    (status),
    .cmd_req   (cmd_req),
    .cmd_code  (cmd_code),
    .cmd_wdata (cmd_wdata),
    .cmd_ack   (cmd_ack),
    .sup_prog  (sup_prog),
    .sup_min   (sup_min),
    .sup_max   (sup_max)
);

// File: tb/prog_algo_seq_tb.sv
module prog_algo_seq_tb;
    localparam int CPU   = 1;
    localparam int PUS   = 100;
    localparam int U     = 4;
    localparam int IMG   = U + 5;
    localparam int IAW   = $clog2(IMG);
    localparam int PULSE = CPU * PUS;
    localparam int GAP   = CPU;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           start = 1'b0;
    logic           done;
    logic [2:0]     status;
    logic           cmd_req;
    logic [2:0]     cmd_code;
    logic [13:0]    cmd_wdata;
    logic           cmd_ack = 1'b0;
    logic [13:0]    cmd_rdata = '0;
    logic [IAW-1:0] img_addr;
    logic [13:0]    img_data;
    logic           sup_prog, sup_min, sup_max;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [13:0] img_word(int a);
        return 14'((a * 421 + 291) % 16000);
    endfunction

    assign img_data = img_word(int'(img_addr));

    prog_algo_seq #(
        .CLK_PER_US(CPU), .PULSE_US(PUS), .GAP_US(1),
        .USER_WORDS(U), .MAX_TRIES(25), .CFG_CYCLES(100)
    ) u_dut (
        .clk(clk), .rst(rst), .start(start), .done(done), .status(status),
        .cmd_req(cmd_req), .cmd_code(cmd_code), .cmd_wdata(cmd_wdata),
        .cmd_ack(cmd_ack), .cmd_rdata(cmd_rdata), .img_addr(img_addr),
        .img_data(img_data), .sup_prog(sup_prog), .sup_min(sup_min),
        .sup_max(sup_max)
    );

    // ---------------- engine model ----------------
    int          need   [IMG];
    int          pulses [IMG];
    logic [13:0] stored [IMG];
    int          pc;
    bit          cfg_sp, loaded, saw_max;
    logic [13:0] latch;
    int          fault_min, fault_max;
    int          dly, low_cnt, rise_cyc, begin_cyc;
    logic        req_prev;
    logic [2:0]  code_prev;
    logic [13:0] wdata_prev;
    int v_hold, v_gap, v_load, v_pulse, v_sup, v_data;

    function automatic int cur_loc();
        if (!cfg_sp) return (pc < U) ? pc : -1;
        if (pc < 4)  return U + pc;
        if (pc == 7) return U + 4;
        return -1;
    endfunction

    task automatic do_cmd();
        int l;
        case (cmd_code)
            3'd6: begin pc = 0; cfg_sp = 0; loaded = 0; end
            3'd0: begin
                cfg_sp = 1; pc = 0; latch = cmd_wdata; loaded = 1;
                if (cmd_wdata != img_word(U)) v_data++;
            end
            3'd1: begin
                l = cur_loc(); latch = cmd_wdata; loaded = 1;
                if (l < 0 || cmd_wdata != img_word(l)) v_data++;
            end
            3'd4: begin
                l = cur_loc();
                if (!loaded) v_load++;
                if (!sup_prog) v_sup++;
                if (l >= 0) begin pulses[l]++; stored[l] = latch; end
                loaded = 0; begin_cyc = cyc;
            end
            3'd5: if (rise_cyc - begin_cyc < PULSE) v_pulse++;
            3'd2: begin
                l = cur_loc();
                if ($countones({sup_prog, sup_min, sup_max}) != 1) v_sup++;
                if (l < 0) cmd_rdata = '0;
                else begin
                    cmd_rdata = (pulses[l] >= need[l]) ? stored[l] : 14'h3FFF;
                    if (sup_min && l == fault_min) cmd_rdata = cmd_rdata ^ 14'h1;
                    if (sup_max && l == fault_max) cmd_rdata = cmd_rdata ^ 14'h1;
                end
            end
            3'd3: pc++;
            default: v_hold++;
        endcase
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (sup_max) saw_max = 1;
            if (cmd_ack && cmd_req) v_hold++;
            if (cmd_req && req_prev && !cmd_ack &&
                (cmd_code != code_prev || cmd_wdata != wdata_prev)) v_hold++;
            if (cmd_req && !req_prev) begin
                if (low_cnt < GAP) v_gap++;
                low_cnt = 0; rise_cyc = cyc;
            end
            if (!cmd_req) low_cnt++;
            req_prev = cmd_req; code_prev = cmd_code; wdata_prev = cmd_wdata;
            if (cmd_ack) cmd_ack = 1'b0;
            else if (cmd_req) begin
                if (dly == 1) begin dly = 0; cmd_ack = 1'b1; do_cmd(); end
                else dly++;
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic prep();
        for (int i = 0; i < IMG; i++) begin need[i] = 1; pulses[i] = 0; stored[i] = 14'h3FFF; end
        pc = 0; cfg_sp = 0; loaded = 0; saw_max = 0; fault_min = -1; fault_max = -1;
        dly = 0; low_cnt = 100; req_prev = 0;
        v_hold = 0; v_gap = 0; v_load = 0; v_pulse = 0; v_sup = 0; v_data = 0;
    endtask

    task automatic go_wait();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        while (!done) @(negedge clk);
    endtask

    task automatic protocol_checks();
        chk(v_hold == 0,  "R1 request held until ack", v_hold, 0);
        chk(v_gap == 0,   "R2 gap between commands", v_gap, 0);
        chk(v_load == 0,  "R3 load before every pulse", v_load, 0);
        chk(v_pulse == 0, "R3 pulse width", v_pulse, 0);
        chk(v_sup == 0,   "R10 supply at pulse and read", v_sup, 0);
        chk(v_data == 0,  "R12 load data equals image", v_data, 0);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk(done == 0, "R11 reset done", int'(done), 0);
        chk(cmd_req == 0, "R11 reset request", int'(cmd_req), 0);
        chk({sup_prog, sup_min, sup_max} == 3'b000, "R11 reset supplies",
            int'({sup_prog, sup_min, sup_max}), 0);
    endtask

    task automatic t_all_pass();
        logic [2:0] st0;
        prep();
        need[0] = 1; need[1] = 3; need[2] = 25; need[3] = 2;
        need[U] = 1; need[U+1] = 2; need[U+2] = 1; need[U+3] = 1;
        go_wait();
        chk(status == 3'd0, "R11 pass status", int'(status), 0);
        for (int i = 0; i < U; i++)
            chk(pulses[i] == 4 * need[i], "R4 pulses per user word", pulses[i], 4 * need[i]);
        for (int i = U; i < U + 4; i++)
            chk(pulses[i] == 4 * need[i], "R8 pulses per id word", pulses[i], 4 * need[i]);
        chk(pulses[U+4] == 100, "R9 configuration pulses", pulses[U+4], 100);
        chk(saw_max == 1, "R7 high-supply verify reached", int'(saw_max), 1);
        protocol_checks();
        st0 = status;
        repeat (6) @(negedge clk);
        chk(done == 1 && status == st0 && !cmd_req, "R11 result holds", int'(status), int'(st0));
    endtask

    task automatic t_prog_fail();
        prep();
        need[1] = 26;
        go_wait();
        chk(status == 3'd1, "R5 program failure status", int'(status), 1);
        chk(pulses[1] == 25, "R5 pulses on failing word", pulses[1], 25);
        chk(pulses[2] == 0, "R5 later word untouched", pulses[2], 0);
        chk(pulses[0] == 4, "R4 single-attempt word", pulses[0], 4);
        protocol_checks();
    endtask

    task automatic t_min_fail();
        prep();
        fault_min = 2;
        go_wait();
        chk(status == 3'd2, "R6 low-supply error status", int'(status), 2);
        chk(saw_max == 0, "R6 high supply never raised", int'(saw_max), 0);
        protocol_checks();
    endtask

    task automatic t_max_fail();
        prep();
        fault_max = 3;
        go_wait();
        chk(status == 3'd3, "R7 high-supply error status", int'(status), 3);
        chk(pulses[U] == 0, "R7 no id programming", pulses[U], 0);
        protocol_checks();
    endtask

    task automatic t_id_fail();
        prep();
        need[U+1] = 27;
        go_wait();
        chk(status == 3'd4, "R8 id failure status", int'(status), 4);
        chk(pulses[U+1] == 25, "R8 pulses on failing id word", pulses[U+1], 25);
        chk(pulses[U+4] == 0, "R8 configuration untouched", pulses[U+4], 0);
        protocol_checks();
    endtask

    task automatic t_cfg_fail();
        prep();
        fault_max = U + 4;
        go_wait();
        chk(status == 3'd4, "R9 configuration corner status", int'(status), 4);
        chk(pulses[U+4] == 100, "R9 configuration pulses", pulses[U+4], 100);
        protocol_checks();
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected done", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", checks + 1, fails);
        $finish;
    end

    initial begin
        prep();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_all_pass();
        t_prog_fail();
        t_min_fail();
        t_max_fail();
        t_id_fail();
        t_cfg_fail();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule